// File: doc/BRIEF.md
# Bidirectional Blit Address Sequencer

This block walks a rectangle of bytes for a block transfer engine. It produces one set of byte addresses per beat: a source address, a destination address and a pattern-row address. A start pulse loads the job. The job gives the start addresses, a separate line pitch for source and destination, the width in bytes, the height in lines, and a mode word. The mode word sets the walk order on each axis, the first row of an 8x8 pattern, and whether the pattern is a solid brush. The block never touches memory and never sees pixel data.

Beats leave on a valid/ready handshake. Each beat carries start-of-line, end-of-line and last flags, so the downstream datapath can frame lines without counting. Each axis can be reversed on its own. A caller that copies between overlapping regions picks the order that reads each byte before it is overwritten. All address arithmetic wraps at 21 bits.

Top module: `blit_addr_seq`

## Requirements
- R1: A start pulse is taken only while `busy_o` is low. A start pulse while busy has no effect on the running job. `busy_o` is high from the cycle after a start is taken until the `done_o` cycle, inclusive.
- R2: When mode bit 9 is 1, beats within a line go left to right. The first beat of a line uses the line base, and each later beat is one byte higher on both source and destination. A line has exactly `width_i` beats.
- R3: When mode bit 9 is 0, beats within a line go right to left. Each beat after the first is one byte lower than the previous one.
- R4: When mode bit 8 is 1, lines go top to bottom. The source line base grows by `src_pitch_i` and the destination line base by `dst_pitch_i`, each on its own, after every line. There are exactly `height_i` lines.
- R5: When mode bit 8 is 0, lines go bottom to top. Each line base shrinks by its own pitch after every line.
- R6: The pattern row starts at mode bits 18:16. It moves by one per line in the same direction as the Y walk and wraps modulo 8. `pat_addr_o` equals the pattern base plus the row times 8.
- R7: When mode bit 19 is 1 (solid brush), `pat_row_o` is 0 and `pat_addr_o` equals the pattern base on every beat, whatever mode bits 18:16 hold.
- R8: A width or height of zero produces no beat. `done_o` pulses in the cycle after the start pulse.
- R9: Source, destination and pattern addresses wrap modulo 2^21, in both the increasing and the decreasing direction.
- R10: While `beat_valid_o` is high and `beat_ready_i` is low, the beat and all its outputs stay unchanged.
- R11: `sol_o` marks the first beat of each line and `eol_o` the final beat of each line. `last_o` marks only the final beat of the job, which is also an end-of-line beat.
- R12: `done_o` is a single-cycle pulse. It comes in the cycle after the last beat is accepted, and `beat_valid_o` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; job inputs are sampled with it |
| mode_i | input | 20 | Mode: bit 8 Y order, bit 9 X order, bits 18:16 first pattern row, bit 19 solid brush |
| src_base_i | input | 21 | Source start byte address |
| dst_base_i | input | 21 | Destination start byte address |
| pat_base_i | input | 21 | Pattern block base address |
| src_pitch_i | input | 12 | Source line pitch in bytes |
| dst_pitch_i | input | 12 | Destination line pitch in bytes |
| width_i | input | 12 | Bytes per line |
| height_i | input | 12 | Lines in the rectangle |
| beat_ready_i | input | 1 | Consumer accepts the current beat |
| beat_valid_o | output | 1 | Beat outputs are valid |
| src_addr_o | output | 21 | Source byte address of the beat |
| dst_addr_o | output | 21 | Destination byte address of the beat |
| pat_addr_o | output | 21 | Address of the current pattern row |
| pat_row_o | output | 3 | Current pattern row index |
| sol_o | output | 1 | First beat of a line |
| eol_o | output | 1 | Final beat of a line |
| last_o | output | 1 | Final beat of the job |
| busy_o | output | 1 | A job is running or finishing |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench runs all four combinations of X and Y order. Each combination uses unequal source and destination pitches and a different first pattern row, so a swapped pitch, an inverted axis or a wrong row direction shows up as an address mismatch. A solid-brush job, jobs of zero width and of zero height, a 1x1 job and jobs that cross the 21-bit boundary both upward and downward cover the edges. A start pulse issued in the middle of a job tests that it is ignored. The consumer's ready signal switches between always-ready and several stall patterns, which separates holding a beat from advancing it.

// File: rtl/blit_seq_pkg.sv
package blit_seq_pkg;
  localparam int MODE_W       = 20;
  localparam int MODE_Y_FWD   = 8;
  localparam int MODE_X_FWD   = 9;
  localparam int MODE_ROW_LSB = 16;
  localparam int MODE_SOLID   = 19;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/blit_line_stepper.sv
module blit_line_stepper #(
  parameter int AW = 21,
  parameter int PW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          fwd_i,
  input  logic [AW-1:0] base_i,
  input  logic [PW-1:0] pitch_i,
  output logic [AW-1:0] line_o
);
  logic [AW-1:0] line_q;
  logic [PW-1:0] pitch_q;
  logic [AW-1:0] pitch_ext;

  assign pitch_ext = {{(AW-PW){1'b0}}, pitch_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      pitch_q <= '0;
    end else if (load_i) begin
      line_q  <= base_i;
      pitch_q <= pitch_i;
    end else if (step_i) begin
      line_q  <= fwd_i ? line_q + pitch_ext : line_q - pitch_ext;
    end
  end

  assign line_o = line_q;
endmodule

// File: rtl/blit_beat_ctr.sv
module blit_beat_ctr #(
  parameter int DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] width_i,
  input  logic [DW-1:0] height_i,
  input  logic          step_i,
  output logic [DW-1:0] col_o,
  output logic          sol_o,
  output logic          eol_o,
  output logic          last_o
);
  logic [DW-1:0] col_q, line_q, width_q, height_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q    <= '0;
      line_q   <= '0;
      width_q  <= '0;
      height_q <= '0;
    end else if (load_i) begin
      col_q    <= '0;
      line_q   <= '0;
      width_q  <= width_i;
      height_q <= height_i;
    end else if (step_i) begin
      if (eol_o) begin
        col_q  <= '0;
        line_q <= line_q + 1'b1;
      end else begin
        col_q  <= col_q + 1'b1;
      end
    end
  end

  assign col_o  = col_q;
  assign sol_o  = (col_q == '0);
  assign eol_o  = (col_q == width_q - 1'b1);
  assign last_o = eol_o && (line_q == height_q - 1'b1);
endmodule

// File: rtl/blit_pat_tracker.sv
module blit_pat_tracker #(
  parameter int AW            = 21,
  parameter int PAT_ROWS      = 8,
  parameter int PAT_ROW_BYTES = 8,
  localparam int RW           = $clog2(PAT_ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [RW-1:0] row_i,
  input  logic          solid_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  input  logic          fwd_i,
  output logic [RW-1:0] row_o,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] ROW_BYTES = AW'(PAT_ROW_BYTES);

  logic [RW-1:0] row_q;
  logic          solid_q;
  logic [AW-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q   <= '0;
      solid_q <= 1'b0;
      base_q  <= '0;
    end else if (load_i) begin
      row_q   <= row_i;
      solid_q <= solid_i;
      base_q  <= base_i;
    end else if (step_i) begin
      // PAT_ROWS is a power of two, so the counter wraps by itself
      row_q <= fwd_i ? row_q + 1'b1 : row_q - 1'b1;
    end
  end

  assign row_o  = solid_q ? '0 : row_q;
  assign addr_o = base_q + AW'(row_o) * ROW_BYTES;
endmodule

// File: rtl/blit_addr_seq.sv
module blit_addr_seq
  import blit_seq_pkg::*;
#(
  parameter int AW            = 21,
  parameter int PW            = 12,
  parameter int DW            = 12,
  parameter int PAT_ROWS      = 8,
  parameter int PAT_ROW_BYTES = 8,
  localparam int RW           = $clog2(PAT_ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [AW-1:0]     src_base_i,
  input  logic [AW-1:0]     dst_base_i,
  input  logic [AW-1:0]     pat_base_i,
  input  logic [PW-1:0]     src_pitch_i,
  input  logic [PW-1:0]     dst_pitch_i,
  input  logic [DW-1:0]     width_i,
  input  logic [DW-1:0]     height_i,
  input  logic              beat_ready_i,
  output logic              beat_valid_o,
  output logic [AW-1:0]     src_addr_o,
  output logic [AW-1:0]     dst_addr_o,
  output logic [AW-1:0]     pat_addr_o,
  output logic [RW-1:0]     pat_row_o,
  output logic              sol_o,
  output logic              eol_o,
  output logic              last_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int NCH = 2;

  seq_state_e    state_q;
  logic          x_fwd_q, y_fwd_q, solid_q;
  logic          load, fire, line_step, empty_job;
  logic [DW-1:0] col;
  logic [AW-1:0] col_ext;

  logic [AW-1:0] ch_base  [NCH];
  logic [PW-1:0] ch_pitch [NCH];
  logic [AW-1:0] ch_line  [NCH];
  logic [AW-1:0] ch_addr  [NCH];

  assign load         = start_i && (state_q == ST_IDLE);
  assign empty_job    = (width_i == '0) || (height_i == '0);
  assign beat_valid_o = (state_q == ST_RUN);
  assign fire         = beat_valid_o && beat_ready_i;
  assign line_step    = fire && eol_o;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      x_fwd_q <= 1'b1;
      y_fwd_q <= 1'b1;
      solid_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          x_fwd_q <= mode_i[MODE_X_FWD];
          y_fwd_q <= mode_i[MODE_Y_FWD];
          solid_q <= mode_i[MODE_SOLID];
          state_q <= empty_job ? ST_DONE : ST_RUN;
        end
        ST_RUN:  if (fire && last_o) state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  blit_beat_ctr #(.DW(DW)) u_beat_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .width_i  (width_i),
    .height_i (height_i),
    .step_i   (fire),
    .col_o    (col),
    .sol_o    (sol_o),
    .eol_o    (eol_o),
    .last_o   (last_o)
  );

  assign col_ext     = {{(AW-DW){1'b0}}, col};
  assign ch_base[0]  = src_base_i;
  assign ch_base[1]  = dst_base_i;
  assign ch_pitch[0] = src_pitch_i;
  assign ch_pitch[1] = dst_pitch_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    blit_line_stepper #(.AW(AW), .PW(PW)) u_line (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load),
      .step_i  (line_step),
      .fwd_i   (y_fwd_q),
      .base_i  (ch_base[c]),
      .pitch_i (ch_pitch[c]),
      .line_o  (ch_line[c])
    );
    assign ch_addr[c] = x_fwd_q ? ch_line[c] + col_ext : ch_line[c] - col_ext;
  end

  assign src_addr_o = ch_addr[0];
  assign dst_addr_o = ch_addr[1];

  blit_pat_tracker #(
    .AW(AW), .PAT_ROWS(PAT_ROWS), .PAT_ROW_BYTES(PAT_ROW_BYTES)
  ) u_pat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .row_i   (mode_i[MODE_ROW_LSB +: RW]),
    .solid_i (mode_i[MODE_SOLID]),
    .base_i  (pat_base_i),
    .step_i  (line_step),
    .fwd_i   (y_fwd_q),
    .row_o   (pat_row_o),
    .addr_o  (pat_addr_o)
  );
endmodule

// File: rtl/blit_addr_seq_chk.sv
module blit_addr_seq_chk #(
  parameter int AW = 21,
  parameter int RW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          beat_valid_o,
  input logic          beat_ready_i,
  input logic [AW-1:0] src_addr_o,
  input logic [AW-1:0] dst_addr_o,
  input logic [AW-1:0] pat_addr_o,
  input logic [RW-1:0] pat_row_o,
  input logic          sol_o,
  input logic          eol_o,
  input logic          last_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          x_fwd_q,
  input logic          solid_q
);
  p_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o || done_o) |-> busy_o);

  p_busy_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && start_i) |=> busy_o);

  p_xstep_fwd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && beat_ready_i && !eol_o && x_fwd_q) |=>
      (beat_valid_o && !sol_o && src_addr_o == AW'($past(src_addr_o) + 1'b1)
       && dst_addr_o == AW'($past(dst_addr_o) + 1'b1)));

  p_xstep_rev_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && beat_ready_i && !eol_o && !x_fwd_q) |=>
      (beat_valid_o && src_addr_o == AW'($past(src_addr_o) - 1'b1)
       && dst_addr_o == AW'($past(dst_addr_o) - 1'b1)));

  p_solid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && solid_q) |-> (pat_row_o == '0));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && !beat_ready_i) |=>
      (beat_valid_o && $stable(src_addr_o) && $stable(dst_addr_o)
       && $stable(pat_addr_o) && $stable(last_o) && $stable(sol_o)));

  p_line_start_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && beat_ready_i && eol_o && !last_o) |=> (beat_valid_o && sol_o));

  p_last_eol_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && last_o) |-> eol_o);

  p_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && beat_ready_i && last_o) |=> (done_o && !beat_valid_o));

  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind blit_addr_seq blit_addr_seq_chk #(.AW(AW), .RW(RW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .beat_valid_o (beat_valid_o),
  .beat_ready_i (beat_ready_i),
  .src_addr_o   (src_addr_o),
  .dst_addr_o   (dst_addr_o),
  .pat_addr_o   (pat_addr_o),
  .pat_row_o    (pat_row_o),
  .sol_o        (sol_o),
  .eol_o        (eol_o),
  .last_o       (last_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .x_fwd_q      (x_fwd_q),
  .solid_q      (solid_q)
);

// File: tb/blit_addr_seq_test.sv
module blit_addr_seq_test;
  localparam int MASK = 'h1F_FFFF;

  typedef struct {
    int unsigned s, d, p;
    int          row;
    bit          sol, eol, last;
  } beat_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [19:0] mode_i = '0;
  logic [20:0] src_base_i = '0, dst_base_i = '0, pat_base_i = '0;
  logic [11:0] src_pitch_i = '0, dst_pitch_i = '0, width_i = '0, height_i = '0;
  logic        beat_ready_i = 1'b0;
  logic        beat_valid_o;
  logic [20:0] src_addr_o, dst_addr_o, pat_addr_o;
  logic [2:0]  pat_row_o;
  logic        sol_o, eol_o, last_o, busy_o, done_o;

  int    checks = 0, errors = 0, cyc = 0, rdy_mode = 0;
  bit    exp_done = 0;
  string req = "R1";
  beat_t q[$];

  always #5 clk_i = ~clk_i;

  blit_addr_seq uut (.*);

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  function automatic bit pick_ready();
    case (rdy_mode)
      0: return 1'b1;
      1: return (cyc % 3) != 0;
      2: return (cyc % 4) == 1;
      default: return ((cyc * 7 + 3) % 5) > 1;
    endcase
  endfunction

  task automatic tick();
    bit rdy;
    @(negedge clk_i);
    cyc++;
    chk(beat_valid_o == (q.size() > 0), {req, "/R12 valid"}, beat_valid_o, q.size() > 0);
    chk(done_o == exp_done, "R8/R12 done", done_o, exp_done);
    chk(busy_o == (q.size() > 0 || exp_done), "R1 busy", busy_o, q.size() > 0 || exp_done);
    if (beat_valid_o && q.size() > 0) begin
      chk(src_addr_o == q[0].s, {req, " src"}, src_addr_o, q[0].s);
      chk(dst_addr_o == q[0].d, {req, " dst"}, dst_addr_o, q[0].d);
      chk(pat_addr_o == q[0].p, {req, " R6 pat_addr"}, pat_addr_o, q[0].p);
      chk(pat_row_o == q[0].row, {req, " R6 row"}, pat_row_o, q[0].row);
      chk({sol_o, eol_o, last_o} == {q[0].sol, q[0].eol, q[0].last}, "R11 flags",
          {sol_o, eol_o, last_o}, {q[0].sol, q[0].eol, q[0].last});
    end
    exp_done = 0;
    rdy = pick_ready();
    if (beat_valid_o && rdy && q.size() > 0) begin
      if (q[0].last) exp_done = 1;
      void'(q.pop_front());
    end
    beat_ready_i = rdy;
  endtask

  task automatic launch(input int sb, db, pb, sp, dp, w, h, input bit xf, yf, sol,
                        input int row0, input bit ignored);
    mode_i      = 20'h000CC | (20'(yf) << 8) | (20'(xf) << 9) | (20'(row0) << 16)
                | (20'(sol) << 19);
    src_base_i  = 21'(sb);  dst_base_i  = 21'(db);  pat_base_i = 21'(pb);
    src_pitch_i = 12'(sp);  dst_pitch_i = 12'(dp);
    width_i     = 12'(w);   height_i    = 12'(h);
    start_i     = 1'b1;
    if (!ignored) begin
      if (w == 0 || h == 0) exp_done = 1;
      for (int j = 0; j < h; j++) begin
        int sl, dl, r;
        sl = yf ? sb + j * sp : sb - j * sp;
        dl = yf ? db + j * dp : db - j * dp;
        r  = yf ? (row0 + j) & 7 : (row0 - j) & 7;
        if (sol) r = 0;
        for (int k = 0; k < w; k++) begin
          beat_t b;
          b.s    = (xf ? sl + k : sl - k) & MASK;
          b.d    = (xf ? dl + k : dl - k) & MASK;
          b.row  = r;
          b.p    = (pb + r * 8) & MASK;
          b.sol  = (k == 0);
          b.eol  = (k == w - 1);
          b.last = (k == w - 1) && (j == h - 1);
          q.push_back(b);
        end
      end
    end
    tick();
    start_i = 1'b0;
    mode_i  = 20'hFFFFF;
  endtask

  task automatic drain();
    while (q.size() > 0 || exp_done) tick();
    tick();
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!beat_valid_o && !busy_o && !done_o, "R1 reset state",
        {beat_valid_o, busy_o, done_o}, 0);
    rst_ni = 1'b1;
    tick();

    req = "R2 R4"; rdy_mode = 0;
    launch('h1000, 'h8000, 'h400, 'h40, 'h100, 4, 3, 1, 1, 0, 2, 0); drain();

    req = "R3 R4 R10"; rdy_mode = 1;
    launch('h2010, 'h9020, 'h400, 'h80, 'h20, 5, 2, 0, 1, 0, 6, 0); drain();

    req = "R2 R5 R6"; rdy_mode = 2;
    launch('h3000, 'hA000, 'h800, 'h30, 'h50, 3, 4, 1, 0, 0, 1, 0); drain();

    req = "R3 R5 R6"; rdy_mode = 3;
    launch('h5000, 'h6000, 'h808, 'h10, 'h200, 2, 10, 0, 0, 0, 5, 0); drain();

    req = "R7"; rdy_mode = 1;
    launch('h100, 'h200, 'hC00, 'h20, 'h20, 3, 3, 1, 1, 1, 3, 0); drain();

    req = "R8"; rdy_mode = 0;
    launch('h100, 'h200, 'h0, 'h20, 'h20, 0, 5, 1, 1, 0, 0, 0); drain();
    launch('h100, 'h200, 'h0, 'h20, 'h20, 7, 0, 0, 0, 0, 0, 0); drain();

    req = "R9"; rdy_mode = 3;
    launch('h1FFFFE, 'h1, 'h1FFFF8, 'hFFF, 'h800, 4, 3, 1, 0, 0, 1, 0); drain();
    launch('h1FFFFD, 'h2, 'h1FFFF0, 'h3, 'hFFF, 3, 3, 0, 1, 0, 7, 0); drain();

    req = "R11"; rdy_mode = 0;
    launch('h77, 'h88, 'h40, 'h1, 'h1, 1, 1, 0, 0, 0, 4, 0); drain();

    req = "R1"; rdy_mode = 2;
    launch('h4000, 'h4800, 'h100, 'h40, 'h40, 3, 2, 1, 1, 0, 0, 0);
    tick(); tick();
    launch('h0, 'h0, 'h0, 'h1, 'h1, 9, 9, 0, 0, 1, 3, 1);
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule